// File: doc/BRIEF.md
# Transmit Queue Teardown Controller

This block sequences the orderly shutdown of a single transmit message queue. Software asks for a teardown by pulsing a request input. From then on the block refuses every new message start. It lets any message that has already begun run to the end, and it waits until every segment still in flight has been answered. It then performs a single finalization step.

Finalization takes one of two paths, depending on whether another buffer descriptor is queued at that moment. If one is, the block issues a write strobe that marks that descriptor with the teardown flag. In the same cycle it strobes a clear of the head pointer register, writes the all-ones-except-two-LSBs sentinel into the completion pointer register, and raises the queue interrupt for one cycle. If no descriptor is queued, the block drives none of these strobes.

On either path the block then clears its own command bit, and the queue returns to idle. The memory transactions behind the strobes, and the reinitialization of the queue, belong to the surrounding logic.

Top module: `txq_teardown_ctrl`

## Requirements
- R1: After reset, `td_cmd`, `td_busy`, `desc_td_flag_wr`, `hdp_clr`, `cp_wr` and `q_irq` are low, and `cp_wdata` is zero.
- R2: A `td_req` pulse while idle drives `td_busy` high in the same cycle and sets `td_cmd` at the next clock edge. Both stay high until the teardown finishes.
- R3: `msg_start_gnt` equals `msg_start_req` while `td_busy` is low, and is low whenever `td_busy` is high.
- R4: No finalization strobe occurs while `msg_active` is high.
- R5: No finalization strobe occurs while `inflight_cnt` is nonzero. This covers a message cut short by an error response, which waits for its remaining segments to be answered.
- R6: If `desc_avail` is high when finalization runs, `desc_td_flag_wr`, `hdp_clr`, `cp_wr` and `q_irq` are all high for exactly one and the same cycle, with `cp_wdata` = 32'hFFFFFFFC.
- R7: If `desc_avail` is low when finalization runs, none of `desc_td_flag_wr`, `hdp_clr`, `cp_wr` or `q_irq` is asserted.
- R8: The block clears `td_cmd` by itself one clock after the finalization cycle, and `td_busy` then falls.
- R9: A `td_req` that arrives while a teardown is in progress is ignored. The teardown finalizes exactly once, and the block stays idle afterwards.
- R10: The choice of finalization path uses `desc_avail` at finalization time. A queue that empties while its last message completes takes the inactive path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| td_req | input | 1 | Software pulse requesting teardown |
| msg_start_req | input | 1 | Transmitter asks to start a new message |
| msg_active | input | 1 | A started message has segments still to send |
| inflight_cnt | input | CNT_W | Segments sent and awaiting a response |
| desc_avail | input | 1 | Another buffer descriptor is queued |
| msg_start_gnt | output | 1 | Permission to start the requested message |
| td_cmd | output | 1 | Teardown command bit |
| td_busy | output | 1 | Teardown in progress |
| desc_td_flag_wr | output | 1 | Strobe: write teardown flag into next descriptor |
| hdp_clr | output | 1 | Strobe: clear head descriptor pointer |
| cp_wr | output | 1 | Strobe: write completion pointer |
| cp_wdata | output | PTR_W | Completion pointer value |
| q_irq | output | 1 | Queue interrupt pulse |

## Verification
The hardest situation to reach is a queue that is active when teardown is requested but empty by the time finalization runs. The bench holds `desc_avail` high with a message in progress and issues the request. It then drops `msg_active` and `desc_avail` in the same cycle and expects no strobes. A second hard case is the error-response drain. Here `msg_active` falls while `inflight_cnt` is still nonzero, and the bench counts it down one step per cycle to confirm that nothing finalizes before it reaches zero.

// File: rtl/txq_td_pkg.sv
// Shared types for the transmit queue teardown controller.
package txq_td_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN_MSG,
        ST_WAIT_RESP,
        ST_FINALIZE,
        ST_DONE
    } td_state_e;
endpackage

// File: rtl/txq_td_cmd.sv
// Teardown command bit and start gating.
// Sets the command bit on a software request taken while the sequencer is
// idle, and clears it when the sequencer reports completion. Assumes that
// idle and done are never both high.
module txq_td_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic td_req,
    input  logic fsm_idle,
    input  logic fsm_done,
    input  logic msg_start_req,
    output logic td_cmd,
    output logic td_busy,
    output logic msg_start_gnt
);
    logic take_req;

    assign take_req = td_req && fsm_idle && !td_cmd;

    // Command bit: set on an accepted request, cleared by hardware at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            td_cmd <= 1'b0;
        else if (fsm_done)
            td_cmd <= 1'b0;
        else if (take_req)
            td_cmd <= 1'b1;
    end

    // Busy covers the request cycle itself, so starts are blocked at once.
    always_comb begin
        td_busy       = td_cmd || take_req;
        msg_start_gnt = msg_start_req && !td_busy;
    end

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |=> td_cmd);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_done |=> !td_cmd);
endmodule

// File: rtl/txq_td_fsm.sv
// Teardown sequencer.
// Walks from the command through message drain and response wait to one
// finalization cycle and a done cycle. Assumes that no new message starts
// once the command is set, which the start gate guarantees.
module txq_td_fsm
    import txq_td_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             td_cmd,
    input  logic             msg_active,
    input  logic [CNT_W-1:0] inflight_cnt,
    input  logic             gnt_mon,
    output logic             is_idle,
    output logic             is_final,
    output logic             is_done
);
    td_state_e state, nxt;
    logic      resp_clear;

    assign resp_clear = (inflight_cnt == '0);

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (td_cmd)      nxt = ST_DRAIN_MSG;
            ST_DRAIN_MSG: if (!msg_active) nxt = ST_WAIT_RESP;
            ST_WAIT_RESP: if (resp_clear)  nxt = ST_FINALIZE;
            ST_FINALIZE:                   nxt = ST_DONE;
            ST_DONE:                       nxt = ST_IDLE;
            default:                       nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Decoded state flags for the neighbours.
    always_comb begin
        is_idle  = (state == ST_IDLE);
        is_final = (state == ST_FINALIZE);
        is_done  = (state == ST_DONE);
    end

    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !gnt_mon);
    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN_MSG && msg_active) |=> (state == ST_DRAIN_MSG));
    p_resp_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RESP && !resp_clear) |=> (state == ST_WAIT_RESP));
endmodule

// File: rtl/txq_td_final.sv
// Finalization strobes.
// Registers one cycle of descriptor-flag, head-clear, completion-pointer and
// interrupt strobes when finalization runs with a descriptor queued. Drives
// nothing on the inactive path.
module txq_td_final #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_final,
    input  logic             desc_avail,
    output logic             desc_td_flag_wr,
    output logic             hdp_clr,
    output logic             cp_wr,
    output logic [PTR_W-1:0] cp_wdata,
    output logic             q_irq
);
    localparam logic [PTR_W-1:0] CP_SENTINEL = {{(PTR_W-2){1'b1}}, 2'b00};

    logic fire;

    assign fire = do_final && desc_avail;

    // Strobe registers for the active finalization path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_td_flag_wr <= 1'b0;
            hdp_clr         <= 1'b0;
            cp_wr           <= 1'b0;
            cp_wdata        <= '0;
            q_irq           <= 1'b0;
        end else begin
            desc_td_flag_wr <= fire;
            hdp_clr         <= fire;
            cp_wr           <= fire;
            cp_wdata        <= fire ? CP_SENTINEL : '0;
            q_irq           <= fire;
        end
    end

    p_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_irq |-> (hdp_clr && cp_wr && desc_td_flag_wr && cp_wdata == CP_SENTINEL));
    p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q_irq |=> !q_irq);
    p_inactive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_final && !desc_avail) |=> (!q_irq && !cp_wr && !hdp_clr && !desc_td_flag_wr));
endmodule

// File: rtl/txq_teardown_ctrl.sv
// Transmit queue teardown controller, top level.
// Wires the command register, the sequencer and the finalization strobes.
// Assumes that inflight_cnt counts only segments already sent and awaiting
// a response.
module txq_teardown_ctrl #(
    parameter int CNT_W = 5,
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             td_req,
    input  logic             msg_start_req,
    input  logic             msg_active,
    input  logic [CNT_W-1:0] inflight_cnt,
    input  logic             desc_avail,
    output logic             msg_start_gnt,
    output logic             td_cmd,
    output logic             td_busy,
    output logic             desc_td_flag_wr,
    output logic             hdp_clr,
    output logic             cp_wr,
    output logic [PTR_W-1:0] cp_wdata,
    output logic             q_irq
);
    logic fsm_idle, fsm_final, fsm_done;

    txq_td_cmd u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .td_req       (td_req),
        .fsm_idle     (fsm_idle),
        .fsm_done     (fsm_done),
        .msg_start_req(msg_start_req),
        .td_cmd       (td_cmd),
        .td_busy      (td_busy),
        .msg_start_gnt(msg_start_gnt)
    );

    txq_td_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .td_cmd      (td_cmd),
        .msg_active  (msg_active),
        .inflight_cnt(inflight_cnt),
        .gnt_mon     (msg_start_gnt),
        .is_idle     (fsm_idle),
        .is_final    (fsm_final),
        .is_done     (fsm_done)
    );

    txq_td_final #(.PTR_W(PTR_W)) u_final (
        .clk            (clk),
        .rst_n          (rst_n),
        .do_final       (fsm_final),
        .desc_avail     (desc_avail),
        .desc_td_flag_wr(desc_td_flag_wr),
        .hdp_clr        (hdp_clr),
        .cp_wr          (cp_wr),
        .cp_wdata       (cp_wdata),
        .q_irq          (q_irq)
    );

    p_irq_before_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_irq |-> td_cmd);
    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_done |=> !td_cmd);
endmodule

// File: tb/sim_txq_teardown_ctrl.sv
module sim_txq_teardown_ctrl;
    localparam int CNT_W = 5;
    localparam int PTR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic td_req = 1'b0, msg_start_req = 1'b0, msg_active = 1'b0, desc_avail = 1'b0;
    logic [CNT_W-1:0] inflight_cnt = '0;
    logic msg_start_gnt, td_cmd, td_busy, desc_td_flag_wr, hdp_clr, cp_wr, q_irq;
    logic [PTR_W-1:0] cp_wdata;

    int checks = 0, errors = 0;
    int n_irq = 0, n_hdp = 0, n_cp = 0, n_desc = 0, n_bad_data = 0;

    always #10 clk = ~clk;

    txq_teardown_ctrl #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u0 (.*);

    // Pulse counters, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (q_irq) n_irq++;
            if (hdp_clr) n_hdp++;
            if (desc_td_flag_wr) n_desc++;
            if (cp_wr) begin
                n_cp++;
                if (cp_wdata != 32'hFFFFFFFC) n_bad_data++;
            end
            if (q_irq && !(hdp_clr && cp_wr && desc_td_flag_wr)) n_bad_data++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        n_irq = 0; n_hdp = 0; n_cp = 0; n_desc = 0; n_bad_data = 0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse td_req for one cycle, driven at negedge.
    task automatic pulse_req();
        td_req = 1'b1;
        #2;
        @(negedge clk);
        td_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && td_busy; i++) @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        #2;
        chk("R1 td_cmd", td_cmd, 0);
        chk("R1 td_busy", td_busy, 0);
        chk("R1 strobes", {desc_td_flag_wr, hdp_clr, cp_wr, q_irq}, 0);
        chk("R1 cp_wdata", cp_wdata, 0);
    endtask

    task automatic t_idle_grant();
        msg_start_req = 1'b1;
        #2;
        chk("R3 grant when idle", msg_start_gnt, 1);
        msg_start_req = 1'b0;
        #2;
        chk("R3 no req no grant", msg_start_gnt, 0);
    endtask

    task automatic t_active_simple();
        clr_counts();
        desc_avail = 1'b1;
        msg_start_req = 1'b1;
        td_req = 1'b1;
        #2;
        chk("R2 busy same cycle", td_busy, 1);
        chk("R3 grant blocked", msg_start_gnt, 0);
        @(negedge clk);
        td_req = 1'b0;
        #2;
        chk("R2 cmd set", td_cmd, 1);
        chk("R3 grant blocked later", msg_start_gnt, 0);
        wait_idle();
        msg_start_req = 1'b0;
        chk("R8 cmd cleared", td_cmd, 0);
        chk("R8 busy low", td_busy, 0);
        chk("R6 irq count", n_irq, 1);
        chk("R6 hdp count", n_hdp, 1);
        chk("R6 cp count", n_cp, 1);
        chk("R6 desc count", n_desc, 1);
        chk("R6 data and grouping", n_bad_data, 0);
        desc_avail = 1'b0;
    endtask

    task automatic t_inactive();
        clr_counts();
        desc_avail = 1'b0;
        pulse_req();
        wait_idle();
        chk("R7 no irq", n_irq, 0);
        chk("R7 no strobes", n_hdp + n_cp + n_desc, 0);
        chk("R8 cmd cleared inactive", td_cmd, 0);
    endtask

    task automatic t_drain();
        clr_counts();
        desc_avail = 1'b1;
        msg_active = 1'b1;
        inflight_cnt = 5'd2;
        pulse_req();
        cycles(10);
        #2;
        chk("R4 held while active", td_cmd, 1);
        chk("R4 no irq while active", n_irq, 0);
        msg_active = 1'b0;
        cycles(8);
        #2;
        chk("R5 held while inflight", td_busy, 1);
        chk("R5 no irq while inflight", n_irq + n_cp, 0);
        inflight_cnt = '0;
        wait_idle();
        chk("R6 irq after drain", n_irq, 1);
        desc_avail = 1'b0;
    endtask

    task automatic t_error_resp();
        clr_counts();
        desc_avail = 1'b1;
        msg_active = 1'b1;
        inflight_cnt = 5'd3;
        pulse_req();
        cycles(2);
        msg_active = 1'b0;   // error response stops further segments
        cycles(4);
        inflight_cnt = 5'd2; @(negedge clk);
        inflight_cnt = 5'd1; @(negedge clk);
        #2;
        chk("R5 no finalize at count 1", n_irq, 0);
        inflight_cnt = 5'd0;
        wait_idle();
        chk("R5 finalize after last response", n_irq, 1);
        desc_avail = 1'b0;
    endtask

    task automatic t_empty_after();
        clr_counts();
        desc_avail = 1'b1;
        msg_active = 1'b1;
        pulse_req();
        cycles(3);
        msg_active = 1'b0;
        desc_avail = 1'b0;
        wait_idle();
        chk("R10 late empty no irq", n_irq, 0);
        chk("R10 late empty no strobes", n_hdp + n_cp + n_desc, 0);
    endtask

    task automatic t_double_req();
        clr_counts();
        desc_avail = 1'b1;
        msg_active = 1'b1;
        pulse_req();
        cycles(3);
        pulse_req();
        cycles(2);
        msg_active = 1'b0;
        wait_idle();
        chk("R9 single finalize", n_irq, 1);
        cycles(10);
        #2;
        chk("R9 stays idle", td_busy, 0);
        chk("R9 no extra irq", n_irq, 1);
        desc_avail = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        t_reset();
        t_idle_grant();
        t_active_simple();
        t_inactive();
        t_drain();
        t_error_resp();
        t_empty_after();
        t_double_req();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule